// File: doc/BRIEF.md
# Prescaled Low-Power Tick Counter

This block is a free-running 24-bit up-counter meant to run from a 32.768 kHz low-frequency clock. A 12-bit reload divider sits in front of the counter. The counter therefore advances at 32768 / (divisor + 1) Hz. A divisor of zero gives one step per clock, about 30.5 µs.

Software drives the block with single-cycle task strobes: start, stop, clear, and force-near-wrap. The force-near-wrap task loads the counter sixteen counts below its wrap point, so that overflow handling can be tested without waiting hours. On every counter step the block can emit a tick pulse, and on every wrap from all-ones to zero it can emit an overflow pulse. Each pulse has its own enable.

The divisor is programmed through a write port, but only while the counter is stopped. The divider's working copy is loaded from the programmed value only when start, clear or force-near-wrap is applied.

Top module: `lpt_top`

## Requirements
- R1: After synchronous reset the counter reads 0, the block is stopped, the programmed divisor reads 0 and no event pulse is high.
- R2: Start sets the running state and loads the divider from the programmed divisor P. The first increment lands P+1 clock edges after the start edge, and later increments follow every P+1 edges.
- R3: Stop clears the running state. The counter then holds its value and the divider holds its position.
- R4: Clear sets the counter to 0 and reloads the divider, and leaves the running state unchanged.
- R5: Force-near-wrap sets the counter to 0xFFFFF0 and reloads the divider, and leaves the running state unchanged.
- R6: A divisor write is stored only while the block is stopped. A write while running is ignored, and the read-back port keeps the old value.
- R7: When the tick enable is 1, every counter increment produces a one-cycle tick pulse in the same cycle that the new count appears.
- R8: When the overflow enable is 1, the step from 0xFFFFFF to 0 produces a one-cycle overflow pulse in the same cycle that the count reads 0.
- R9: With an enable at 0 its pulse stays low, and counting is not affected.
- R10: When several strobes arrive in one cycle, only one is applied, in this priority order: clear, then force-near-wrap, then stop, then start. A task applied in a cycle suppresses that cycle's divider step.
- R11: A divisor write in the same cycle as a reloading task is stored if the block is stopped, but that reload uses the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Clear task strobe |
| force_i | input | 1 | Force-near-wrap task strobe |
| stop_i | input | 1 | Stop task strobe |
| start_i | input | 1 | Start task strobe |
| presc_wr_i | input | 1 | Divisor write enable |
| presc_data_i | input | 12 | Divisor write data |
| tick_en_i | input | 1 | Tick pulse enable |
| ovf_en_i | input | 1 | Overflow pulse enable |
| count_o | output | 24 | Current counter value |
| tick_o | output | 1 | Tick pulse |
| ovf_o | output | 1 | Overflow pulse |
| presc_o | output | 12 | Programmed divisor read-back |
| running_o | output | 1 | Running state |

## Verification
Directed phases try divisors 0 and 2. These show that the step period tracks P+1 and that the first step is counted from the start edge. A force-near-wrap phase with divisor 0 walks the counter through the wrap, which separates the overflow pulse from ordinary ticks. Further phases cover a write while running and a cycle with all strobes together; these separate the write-blocking rule and the task priority from plain counting. A long stretch of seeded random strobes, writes and enable toggles is then compared cycle by cycle with a bench model built from the requirements. This exposes interactions that the directed cases miss, such as reloads that coincide with a write.

// File: rtl/lpt_pkg.sv
// Shared types for the prescaled tick counter.
package lpt_pkg;
    // Action applied in one cycle after strobe priority resolution.
    typedef enum logic [2:0] {
        ACT_NONE  = 3'd0,
        ACT_CLEAR = 3'd1,
        ACT_FORCE = 3'd2,
        ACT_STOP  = 3'd3,
        ACT_START = 3'd4
    } lpt_act_e;
endpackage

// File: rtl/lpt_task_dec.sv
// Resolves simultaneous task strobes into one action.
// Assumes strobes are single-cycle and already in the counting clock domain.
module lpt_task_dec
    import lpt_pkg::*;
(
    input  logic     clear_i,
    input  logic     force_i,
    input  logic     stop_i,
    input  logic     start_i,
    output lpt_act_e act_o
);
    // Fixed priority: clear, force, stop, start.
    always_comb begin
        if (clear_i)      act_o = ACT_CLEAR;
        else if (force_i) act_o = ACT_FORCE;
        else if (stop_i)  act_o = ACT_STOP;
        else if (start_i) act_o = ACT_START;
        else              act_o = ACT_NONE;
    end
endmodule

// File: rtl/lpt_divider.sv
// Programmed divisor register plus reload down-counter producing step strobes.
// Assumes run_i is the registered running state and act_i the resolved action.
module lpt_divider
    import lpt_pkg::*;
#(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  lpt_act_e         act_i,
    input  logic             wr_i,
    input  logic [PRE_W-1:0] wdata_i,
    output logic [PRE_W-1:0] cfg_o,
    output logic             step_o
);
    logic [PRE_W-1:0] cnt_q;
    logic             reload;

    assign reload = (act_i == ACT_CLEAR) || (act_i == ACT_FORCE) || (act_i == ACT_START);
    assign step_o = run_i && (act_i == ACT_NONE) && (cnt_q == '0);

    // Divisor register: writable only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                cfg_o <= '0;
        else if (wr_i && !run_i)   cfg_o <= wdata_i;
    end

    // Working down-counter: reload on tasks, else count down while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                             cnt_q <= '0;
        else if (reload)                        cnt_q <= cfg_o;
        else if (run_i && act_i == ACT_NONE)    cnt_q <= (cnt_q == '0) ? cfg_o : cnt_q - 1'b1;
    end

    a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> $stable(cfg_o));
    a_r2_start_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_START) |=> (cnt_q == $past(cfg_o)));
    a_r3_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && act_i == ACT_NONE) |=> $stable(cnt_q));
endmodule

// File: rtl/lpt_count.sv
// Main counter with tick and overflow pulse generation.
// Assumes step_i is only high when no task is applied in the same cycle.
module lpt_count
    import lpt_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int FORCE_GAP = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lpt_act_e         act_i,
    input  logic             step_i,
    input  logic             tick_en_i,
    input  logic             ovf_en_i,
    output logic [CNT_W-1:0] count_o,
    output logic             tick_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] ALL_ONES  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] FORCE_VAL = ALL_ONES - CNT_W'(FORCE_GAP - 1);

    // Counter value: clear, force, or step.
    always_ff @(posedge clk) begin
        if (!rst_n)                    count_o <= '0;
        else if (act_i == ACT_CLEAR)   count_o <= '0;
        else if (act_i == ACT_FORCE)   count_o <= FORCE_VAL;
        else if (step_i)               count_o <= count_o + 1'b1;
    end

    // Event pulses, aligned with the updated count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_o <= 1'b0;
            ovf_o  <= 1'b0;
        end else begin
            tick_o <= step_i && tick_en_i;
            ovf_o  <= step_i && ovf_en_i && (count_o == ALL_ONES);
        end
    end

    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_CLEAR) |=> (count_o == '0));
    a_r5_force_val: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_FORCE) |=> (count_o == FORCE_VAL));
    a_r8_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (count_o == '0));
    a_r7_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (count_o == $past(count_o) + 1'b1));
endmodule

// File: rtl/lpt_top.sv
// Prescaled low-power tick counter top: task decode, run state, divider, counter.
// Assumes all inputs are synchronous to clk.
module lpt_top
    import lpt_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int PRE_W     = 12,
    parameter int FORCE_GAP = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             force_i,
    input  logic             stop_i,
    input  logic             start_i,
    input  logic             presc_wr_i,
    input  logic [PRE_W-1:0] presc_data_i,
    input  logic             tick_en_i,
    input  logic             ovf_en_i,
    output logic [CNT_W-1:0] count_o,
    output logic             tick_o,
    output logic             ovf_o,
    output logic [PRE_W-1:0] presc_o,
    output logic             running_o
);
    lpt_act_e act;
    logic     step;

    lpt_task_dec u_dec (
        .clear_i (clear_i),
        .force_i (force_i),
        .stop_i  (stop_i),
        .start_i (start_i),
        .act_o   (act)
    );

    // Running state: set by start, cleared by stop.
    always_ff @(posedge clk) begin
        if (!rst_n)                  running_o <= 1'b0;
        else if (act == ACT_STOP)    running_o <= 1'b0;
        else if (act == ACT_START)   running_o <= 1'b1;
    end

    lpt_divider #(.PRE_W(PRE_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (running_o),
        .act_i   (act),
        .wr_i    (presc_wr_i),
        .wdata_i (presc_data_i),
        .cfg_o   (presc_o),
        .step_o  (step)
    );

    lpt_count #(.CNT_W(CNT_W), .FORCE_GAP(FORCE_GAP)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_i     (act),
        .step_i    (step),
        .tick_en_i (tick_en_i),
        .ovf_en_i  (ovf_en_i),
        .count_o   (count_o),
        .tick_o    (tick_o),
        .ovf_o     (ovf_o)
    );

    a_r10_clear_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && start_i && !running_o) |=> !running_o);
    a_r3_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !clear_i && !force_i) |=> !running_o);
    a_r9_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en_i |=> !tick_o);
endmodule

// File: tb/lpt_top_tb_top.sv
// Self-checking bench: directed phases plus seeded random stimulus vs a model.
module lpt_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] FORCE_VAL = 24'hFFFFF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 0, force_i = 0, stop_i = 0, start_i = 0;
    logic        presc_wr_i = 0;
    logic [11:0] presc_data_i = '0;
    logic        tick_en_i = 0, ovf_en_i = 0;
    logic [23:0] count_o;
    logic        tick_o, ovf_o, running_o;
    logic [11:0] presc_o;

    int errors = 0;
    int checks = 0;
    int ovf_seen = 0;
    bit done = 0;
    string tag = "R1";

    // Reference model state
    logic [23:0] m_count;
    logic [11:0] m_cfg, m_div;
    logic        m_run, m_tick, m_ovf;

    lpt_top dut_i (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .force_i(force_i),
        .stop_i(stop_i), .start_i(start_i), .presc_wr_i(presc_wr_i),
        .presc_data_i(presc_data_i), .tick_en_i(tick_en_i), .ovf_en_i(ovf_en_i),
        .count_o(count_o), .tick_o(tick_o), .ovf_o(ovf_o), .presc_o(presc_o),
        .running_o(running_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare all outputs with the model (called at negedge).
    task automatic compare_all();
        chk(tag, {8'd0, count_o}, {8'd0, m_count}, "count");
        chk(tag, {31'd0, tick_o}, {31'd0, m_tick}, "tick");
        chk(tag, {31'd0, ovf_o}, {31'd0, m_ovf}, "ovf");
        chk(tag, {20'd0, presc_o}, {20'd0, m_cfg}, "divisor");
        chk(tag, {31'd0, running_o}, {31'd0, m_run}, "running");
        if (ovf_o) ovf_seen++;
    endtask

    // Model of one clock edge, written from R2..R11.
    task automatic model_edge();
        logic step;
        logic [11:0] old_cfg;
        old_cfg = m_cfg;
        step = 1'b0;
        if (presc_wr_i && !m_run) m_cfg = presc_data_i;          // R6, R11
        m_tick = 1'b0;
        m_ovf = 1'b0;
        if (clear_i) begin                                       // R10 priority
            m_count = '0; m_div = old_cfg;                        // R4
        end else if (force_i) begin
            m_count = FORCE_VAL; m_div = old_cfg;                 // R5
        end else if (stop_i) begin
            m_run = 1'b0;                                         // R3
        end else if (start_i) begin
            m_run = 1'b1; m_div = old_cfg;                        // R2
        end else if (m_run) begin
            if (m_div == 0) begin
                step = 1'b1; m_div = old_cfg;
            end else m_div = m_div - 1;
        end
        if (step) begin
            m_tick = tick_en_i;                                   // R7, R9
            m_ovf = ovf_en_i && (m_count == 24'hFFFFFF);          // R8
            m_count = m_count + 1;
        end
    endtask

    // One cycle: check at negedge, update model, drive inputs for next edge.
    task automatic cycle(input logic cl, input logic fo, input logic sp, input logic st,
                         input logic wr, input logic [11:0] wd, input logic te, input logic oe);
        @(negedge clk);
        compare_all();
        clear_i = cl; force_i = fo; stop_i = sp; start_i = st;
        presc_wr_i = wr; presc_data_i = wd; tick_en_i = te; ovf_en_i = oe;
        model_edge();
    endtask

    task automatic idle(input int n, input logic te, input logic oe);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, '0, te, oe);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int sd;
        m_count = '0; m_cfg = '0; m_div = '0; m_run = 0; m_tick = 0; m_ovf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        tag = "R1"; compare_all();                              // R1 reset state

        // R2: divisor 0, every edge steps, ticks enabled (R7)
        tag = "R2";
        cycle(0, 0, 0, 0, 1, 12'd0, 1, 1);
        cycle(0, 0, 0, 1, 0, '0, 1, 1);
        idle(10, 1, 1);
        // R3: stop holds value
        tag = "R3";
        cycle(0, 0, 1, 0, 0, '0, 1, 1);
        idle(6, 1, 1);
        // R2: divisor 2, period 3
        tag = "R2";
        cycle(0, 0, 0, 0, 1, 12'd2, 1, 0);
        cycle(0, 0, 0, 1, 0, '0, 1, 0);
        idle(14, 1, 0);
        // R6: write while running ignored
        tag = "R6";
        cycle(0, 0, 0, 0, 1, 12'd7, 1, 0);
        idle(4, 1, 0);
        // R4: clear while running keeps running
        tag = "R4";
        cycle(1, 0, 0, 0, 0, '0, 1, 0);
        idle(5, 1, 0);
        // R5 / R8: force to near wrap at divisor 0 and walk through the wrap
        tag = "R5";
        cycle(0, 0, 1, 0, 0, '0, 1, 1);
        cycle(0, 0, 0, 0, 1, 12'd0, 1, 1);
        cycle(0, 1, 0, 0, 0, '0, 1, 1);
        idle(2, 1, 1);
        tag = "R8";
        cycle(0, 0, 0, 1, 0, '0, 1, 1);
        idle(20, 1, 1);
        chk("R8", ovf_seen, 1, "overflow pulses seen");
        // R9: enables off, wrap again silently
        tag = "R9";
        cycle(0, 1, 0, 0, 0, '0, 0, 0);
        idle(20, 0, 0);
        // R10: all strobes together -> clear wins, running unchanged
        tag = "R10";
        cycle(0, 0, 1, 0, 0, '0, 1, 1);
        cycle(1, 1, 1, 1, 0, '0, 1, 1);
        idle(3, 1, 1);
        cycle(0, 1, 1, 1, 0, '0, 1, 1);
        idle(3, 1, 1);
        // R11: write with start while stopped, reload uses old value
        tag = "R11";
        cycle(0, 0, 1, 0, 0, '0, 1, 1);
        cycle(0, 0, 0, 0, 1, 12'd3, 1, 1);
        cycle(0, 0, 0, 1, 1, 12'd0, 1, 1);
        idle(12, 1, 1);

        // Random mix
        tag = "R2/R3/R4/R5/R6/R7/R8/R9/R10/R11";
        sd = $urandom(32'h1234_5678);
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            cycle(r < 4, (r >= 4 && r < 8) || (r == 200), (r >= 8 && r < 14), (r >= 14 && r < 24) || (r == 200),
                  ($urandom % 8) == 0, 12'($urandom % 4),
                  ($urandom % 16) != 0, ($urandom % 16) != 0);
        end
        @(negedge clk);
        compare_all();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule